// File: doc/BRIEF.md
# Adaptive Gate-Drive Level Stepper

This block chooses how hard a synchronous-rectifier gate is driven. It has sixteen drive levels. Level n stands for the clamp voltage lowered by (16 − n) steps of 400 mV, so level 16 is the full clamp. Once per switching cycle the block receives the measured transformer demagnetization time, counted in clock ticks. It sorts that time into one of sixteen bins. The bin edges scale with the programmed minimum on-time.

The stored level moves by a single step only when the detected bin has stayed on the same side of the current level for 32 cycles in a row. The drive therefore backs off slowly as the load gets lighter and recovers slowly as it gets heavier.

Three conditions override the filter:
- A low supply-OK flag forces full drive. This flag comes from an external comparator with hysteresis.
- Burst operation freezes adaptation.
- The resume events set fixed start points: the top level after a burst, and the bottom level after sleep. From there the filter steps up gradually.

The level leaves the block as a 4-bit code equal to n − 1.

Top module: `gdrv_level_stepper`

## Requirements
- R1: After reset `lvl_code` is 15. The output encoding is code = n − 1, so code 15 is level 16 (full clamp) and code 0 is level 1.
- R2: Bin edge n (n = 1..16) is OFFSET_TICKS + floor(ton_min·(n+6)/6) ticks. The detected step for a cycle is the largest n whose edge is less than or equal to `demag_ticks`, with a minimum of 1 (code 0).
- R3: If a cycle's detected step is above the current level, and so are the 31 accepted cycles before it with no break, the level rises by one. The new code appears two clock edges after the clock in which `cyc_done` is high.
- R4: If 32 consecutive accepted cycles all detect a step below the current level, the level falls by one, with the same timing as R3.
- R5: The run count restarts in three cases: a cycle detects a step equal to the current level; the direction flips; or a step has just been taken. Each further step needs 32 new cycles.
- R6: While `supply_ok` is 0, the code becomes 15 at the next edge, cycles are ignored and the run count is cleared.
- R7: While `burst_active` is 1, cycles are ignored, the level is held and the run count is cleared.
- R8: A `burst_exit` pulse sets code 15 at the next edge. It takes priority over `sleep_exit` in the same cycle.
- R9: A `sleep_exit` pulse sets code 0 at the next edge. Adaptation then moves upward by the rules of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_done | input | 1 | One-clock strobe: `demag_ticks` holds a new measurement |
| demag_ticks | input | TICK_W | Demagnetization time of the cycle just ended, in ticks |
| ton_min | input | TICK_W | Programmed minimum on-time, in ticks (quasi-static) |
| supply_ok | input | 1 | Supply high enough for adaptive drive (hysteresis applied outside) |
| burst_active | input | 1 | Primary side is in burst mode; adaptation suspended |
| burst_exit | input | 1 | One-clock pulse: switching resumed after burst |
| sleep_exit | input | 1 | One-clock pulse: operation resumed after sleep |
| lvl_code | output | CODE_W | Drive level code, n − 1 |

## Verification
A `cyc_done` strobe is first registered as a detected step. It reaches `lvl_code` at the second edge after the strobe clock. Supply, burst and sleep overrides appear at the first edge. The bench therefore drives at falling edges and leaves two idle clocks after every strobe and one after every event before it samples. Bin edges are checked by converging from level 1 with measurements placed exactly on each edge and one tick below it. Expected levels are computed from the edge formula for two minimum on-time settings. Persistence counts are checked at the 31st and 32nd cycles of a run.

// File: rtl/gdl_pkg.sv
package gdl_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } dir_e;
endpackage

// File: rtl/gdl_thresholds.sv
// Registers one bin edge per drive level from the programmed minimum on-time.
module gdl_thresholds #(
  parameter int TICK_W       = 12,
  parameter int NLEV         = 16,
  parameter int OFFSET_TICKS = 6,
  parameter int THR_W        = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [TICK_W-1:0]       ton_min,
  output logic [NLEV*THR_W-1:0]   thr_flat
);
  logic [THR_W-1:0] ton_ext;
  assign ton_ext = THR_W'(ton_min);

  for (genvar g = 0; g < NLEV; g++) begin : g_edge
    // step n = g+1 : OFFSET + floor(ton*(n+6)/6)   (R2)
    localparam logic [THR_W-1:0] MULT = THR_W'(g + 7);
    logic [THR_W-1:0] edge_q;
    always_ff @(posedge clk) begin
      if (rst) edge_q <= '1;
      else     edge_q <= THR_W'(OFFSET_TICKS) + (ton_ext * MULT) / THR_W'(6);
    end
    assign thr_flat[g*THR_W +: THR_W] = edge_q;
  end

  // Edges must rise with n for the bin count to be a valid step index (R2).
  for (genvar g = 1; g < NLEV; g++) begin : g_mono
    p_edges_rise_r2: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> thr_flat[g*THR_W +: THR_W] >= thr_flat[(g-1)*THR_W +: THR_W]);
  end
endmodule

// File: rtl/gdl_step_detect.sv
// Counts the bin edges passed by one measurement and registers the step code.
module gdl_step_detect #(
  parameter int TICK_W = 12,
  parameter int NLEV   = 16,
  parameter int THR_W  = 18,
  parameter int CODE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cyc_done,
  input  logic [TICK_W-1:0]       demag_ticks,
  input  logic [NLEV*THR_W-1:0]   thr_flat,
  output logic                    det_valid,
  output logic [CODE_W-1:0]       det_code
);
  localparam int CNT_W = $clog2(NLEV + 1);

  logic [THR_W-1:0]  demag_ext;
  logic [CNT_W-1:0]  passed;
  logic [CODE_W-1:0] code_d;

  assign demag_ext = THR_W'(demag_ticks);

  always_comb begin
    passed = '0;
    for (int i = 0; i < NLEV; i++) begin
      if (thr_flat[i*THR_W +: THR_W] <= demag_ext) passed = passed + CNT_W'(1);
    end
    // highest step reached, clamped to step 1 (code 0)   (R2)
    code_d = (passed == '0) ? '0 : CODE_W'(passed - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_valid <= 1'b0;
      det_code  <= '0;
    end else begin
      det_valid <= cyc_done;
      if (cyc_done) det_code <= code_d;
    end
  end

  p_valid_follows_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    cyc_done |=> det_valid);
endmodule

// File: rtl/gdl_persist_filter.sv
// Moves the drive level one step after a run of agreeing cycles; applies overrides.
module gdl_persist_filter
  import gdl_pkg::*;
#(
  parameter int NLEV    = 16,
  parameter int PERSIST = 32,
  parameter int CODE_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              det_valid,
  input  logic [CODE_W-1:0] det_code,
  input  logic              supply_ok,
  input  logic              burst_active,
  input  logic              burst_exit,
  input  logic              sleep_exit,
  output logic [CODE_W-1:0] lvl_code
);
  localparam int               CNT_W    = $clog2(PERSIST + 1);
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(NLEV - 1);
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(PERSIST - 1);

  logic [CODE_W-1:0] lvl_q;
  logic [CNT_W-1:0]  run_q;
  dir_e              dir_q;
  dir_e              want;

  always_comb begin
    if (det_code > lvl_q)      want = DIR_UP;
    else if (det_code < lvl_q) want = DIR_DN;
    else                       want = DIR_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= TOP_CODE;
      run_q <= '0;
      dir_q <= DIR_NONE;
    end else if (!supply_ok) begin           // R6
      lvl_q <= TOP_CODE;
      run_q <= '0;
      dir_q <= DIR_NONE;
    end else if (burst_exit) begin           // R8
      lvl_q <= TOP_CODE;
      run_q <= '0;
      dir_q <= DIR_NONE;
    end else if (sleep_exit) begin           // R9
      lvl_q <= '0;
      run_q <= '0;
      dir_q <= DIR_NONE;
    end else if (burst_active) begin         // R7
      run_q <= '0;
      dir_q <= DIR_NONE;
    end else if (det_valid) begin
      if (want == DIR_NONE) begin            // R5
        run_q <= '0;
        dir_q <= DIR_NONE;
      end else if (want != dir_q) begin      // R5: direction change
        run_q <= CNT_W'(1);
        dir_q <= want;
      end else if (run_q == LAST_CNT) begin  // R3 / R4
        run_q <= '0;
        if (want == DIR_UP) lvl_q <= lvl_q + CODE_W'(1);
        else                lvl_q <= lvl_q - CODE_W'(1);
      end else begin
        run_q <= run_q + CNT_W'(1);
      end
    end
  end

  assign lvl_code = lvl_q;

  initial begin
    a_persist_min: assert (PERSIST >= 2);
  end

  p_run_bound_r5: assert property (@(posedge clk) disable iff (rst)
    run_q < CNT_W'(PERSIST));

  p_supply_full_r6: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> lvl_q == TOP_CODE);

  p_burst_hold_r7: assert property (@(posedge clk) disable iff (rst)
    supply_ok && !burst_exit && !sleep_exit && burst_active |=> $stable(lvl_q));

  p_burst_resume_top_r8: assert property (@(posedge clk) disable iff (rst)
    supply_ok && burst_exit |=> lvl_q == TOP_CODE);

  p_sleep_resume_low_r9: assert property (@(posedge clk) disable iff (rst)
    supply_ok && !burst_exit && sleep_exit |=> lvl_q == '0);

  p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
    supply_ok && !burst_exit && !sleep_exit |=>
      (lvl_q == $past(lvl_q)) || (lvl_q == $past(lvl_q) + CODE_W'(1)) ||
      (lvl_q + CODE_W'(1) == $past(lvl_q)));
endmodule

// File: rtl/gdrv_level_stepper.sv
module gdrv_level_stepper #(
  parameter int TICK_W       = 12,
  parameter int NLEV         = 16,
  parameter int PERSIST      = 32,
  parameter int OFFSET_TICKS = 6,
  parameter int CODE_W       = $clog2(NLEV)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_done,
  input  logic [TICK_W-1:0] demag_ticks,
  input  logic [TICK_W-1:0] ton_min,
  input  logic              supply_ok,
  input  logic              burst_active,
  input  logic              burst_exit,
  input  logic              sleep_exit,
  output logic [CODE_W-1:0] lvl_code
);
  localparam int THR_W = TICK_W + $clog2(NLEV + 7) + 1;

  logic [NLEV*THR_W-1:0] thr_flat;
  logic                  det_valid;
  logic [CODE_W-1:0]     det_code;

  gdl_thresholds #(
    .TICK_W(TICK_W), .NLEV(NLEV), .OFFSET_TICKS(OFFSET_TICKS), .THR_W(THR_W)
  ) u_thr (
    .clk(clk), .rst(rst), .ton_min(ton_min), .thr_flat(thr_flat)
  );

  gdl_step_detect #(
    .TICK_W(TICK_W), .NLEV(NLEV), .THR_W(THR_W), .CODE_W(CODE_W)
  ) u_det (
    .clk(clk), .rst(rst), .cyc_done(cyc_done), .demag_ticks(demag_ticks),
    .thr_flat(thr_flat), .det_valid(det_valid), .det_code(det_code)
  );

  gdl_persist_filter #(
    .NLEV(NLEV), .PERSIST(PERSIST), .CODE_W(CODE_W)
  ) u_flt (
    .clk(clk), .rst(rst), .det_valid(det_valid), .det_code(det_code),
    .supply_ok(supply_ok), .burst_active(burst_active),
    .burst_exit(burst_exit), .sleep_exit(sleep_exit), .lvl_code(lvl_code)
  );
endmodule

// File: tb/test_gdrv_level_stepper.sv
`timescale 1ns/1ps
module test_gdrv_level_stepper;
  localparam int TW = 12;
  localparam int OFF = 6;
  localparam int RUN = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cyc_done = 1'b0;
  logic [TW-1:0] demag_ticks = '0;
  logic [TW-1:0] ton_min = 12'd60;
  logic          supply_ok = 1'b1;
  logic          burst_active = 1'b0;
  logic          burst_exit = 1'b0;
  logic          sleep_exit = 1'b0;
  logic [3:0]    lvl_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gdrv_level_stepper #(.TICK_W(TW), .NLEV(16), .PERSIST(RUN), .OFFSET_TICKS(OFF)) i_gdrv_level_stepper (
    .clk(clk), .rst(rst), .cyc_done(cyc_done), .demag_ticks(demag_ticks),
    .ton_min(ton_min), .supply_ok(supply_ok), .burst_active(burst_active),
    .burst_exit(burst_exit), .sleep_exit(sleep_exit), .lvl_code(lvl_code));

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: lvl_code=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2 edge formula, step n in 1..16
  function automatic int edge_of(input int tm, input int n);
    return OFF + (tm * (n + 6)) / 6;
  endfunction

  function automatic int step_of(input int tm, input int d);
    int s = 1;
    for (int n = 1; n <= 16; n++) if (edge_of(tm, n) <= d) s = n;
    return s;
  endfunction

  task automatic pulse(input int d);
    @(negedge clk); cyc_done = 1'b1; demag_ticks = TW'(d);
    @(negedge clk); cyc_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulses(input int d, input int cnt);
    for (int i = 0; i < cnt; i++) pulse(d);
  endtask

  task automatic ev_sleep();
    @(negedge clk); sleep_exit = 1'b1;
    @(negedge clk); sleep_exit = 1'b0;
  endtask

  task automatic ev_burst();
    @(negedge clk); burst_exit = 1'b1;
    @(negedge clk); burst_exit = 1'b0;
  endtask

  // From level 1, feed d long enough to climb to its step and sit there.
  task automatic converge(input int tm, input int d, input string tag);
    int s = step_of(tm, d);
    ev_sleep();
    pulses(d, RUN * s);
    check(int'(lvl_code), s - 1, tag);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: lvl_code=%0d expected=finish", lvl_code);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(int'(lvl_code), 15, "R1 reset level");

    // R2 sweep of every bin edge, two minimum on-time settings
    foreach (ton_min_set[k]) ;
    for (int k = 0; k < 2; k++) begin
      ton_min = (k == 0) ? 12'd60 : 12'd37;
      repeat (2) @(negedge clk);
      for (int n = 1; n <= 16; n++) begin
        converge(int'(ton_min), edge_of(int'(ton_min), n), "R2 on edge");
        converge(int'(ton_min), edge_of(int'(ton_min), n) - 1, "R2 below edge");
      end
    end
    converge(int'(ton_min), 4095, "R2 above top edge");
    converge(int'(ton_min), 0, "R2 clamp to step 1");

    // R3: 31 rising cycles do not move, the 32nd does
    ev_sleep();
    pulses(4095, RUN - 1);
    check(int'(lvl_code), 0, "R3 after 31 up cycles");
    pulse(4095);
    check(int'(lvl_code), 1, "R3 after 32 up cycles");

    // R4: downward from top
    ev_burst();
    pulses(0, RUN - 1);
    check(int'(lvl_code), 15, "R4 after 31 down cycles");
    pulse(0);
    check(int'(lvl_code), 14, "R4 after 32 down cycles");

    // R5: equal step restarts the run
    ev_sleep();
    pulses(4095, 20);
    pulse(0);                       // step 1 equals level 1
    pulses(4095, RUN - 1);
    check(int'(lvl_code), 0, "R5 equal step restarts run");
    pulse(4095);
    check(int'(lvl_code), 1, "R5 run complete after restart");

    // R5: direction flip restarts the run (level code 1, step 2)
    pulses(4095, 20);
    pulse(0);                       // down once
    pulses(4095, RUN - 1);
    check(int'(lvl_code), 1, "R5 flip restarts run");
    pulse(4095);
    check(int'(lvl_code), 2, "R5 run complete after flip");

    // R7: burst holds level, ignores cycles, clears run
    ev_sleep();
    pulses(4095, 10);
    burst_active = 1'b1;
    pulses(4095, 40);
    check(int'(lvl_code), 0, "R7 hold during burst");
    burst_active = 1'b0;
    pulses(4095, RUN - 1);
    check(int'(lvl_code), 0, "R7 run cleared by burst");
    pulse(4095);
    check(int'(lvl_code), 1, "R7 adaptation resumes");

    // R6: supply low forces top and ignores cycles
    ev_sleep();
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk);
    check(int'(lvl_code), 15, "R6 supply low forces top");
    pulses(0, 40);
    check(int'(lvl_code), 15, "R6 cycles ignored while low");
    supply_ok = 1'b1;
    pulses(0, RUN - 1);
    check(int'(lvl_code), 15, "R6 run cleared while low");

    // R8 / R9 priority and start points
    ev_sleep();
    check(int'(lvl_code), 0, "R9 sleep resume to level 1");
    ev_burst();
    check(int'(lvl_code), 15, "R8 burst resume to top");
    @(negedge clk); burst_exit = 1'b1; sleep_exit = 1'b1;
    @(negedge clk); burst_exit = 1'b0; sleep_exit = 1'b0;
    check(int'(lvl_code), 15, "R8 burst resume wins over sleep resume");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  int ton_min_set[2];
endmodule